// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path. It watches the incoming frame one byte per valid cycle, starting at the first destination-address byte, and after the sixth address byte it decides whether the rest of the frame should be kept. While the bytes arrive it also runs a reflected CRC-32 over them. The top bits of that CRC index a multicast hash table.

The decision depends on four inputs. The station address is programmed as two configuration words. A two-word multicast hash table is also programmed. Two mode pins complete the set: promiscuous mode accepts everything, and a second pin makes the block drop the all-ones broadcast address. The verdict is a one-cycle strobe that carries an accept bit and two class flags, broadcast and multicast. The rest of the receive path uses the strobe to keep or discard the frame. Configuration words are written through a simple write port that has a 2-bit word selector.

Top module: `rx_dst_filter`

## Requirements
- R1: While reset is held and after it is released, `verdict_vld` and `accept` are 0 until a full address has been received.
- R2: `verdict_vld` is high for exactly one cycle, on the clock after the edge that captures the sixth address byte. Only cycles with `byte_vld` high count as bytes, so idle cycles between bytes delay the verdict and never produce one early.
- R3: A unicast address (first wire byte, bit 0 = 0) is accepted only when all 48 bits equal the station address. A difference in any byte rejects it.
- R4: The station address is written through selector 0 and selector 1. Selector 0 takes wire bytes 2, 3, 4 and 5 in data bits 31:24, 23:16, 15:8 and 7:0. Selector 1 takes wire byte 0 in bits 15:8 and wire byte 1 in bits 7:0. Wire byte 0 is the first byte received.
- R5: The all-ones address raises `is_bcast`. It is accepted when `reject_bcast` is 0 and rejected when `reject_bcast` is 1.
- R6: An address whose first byte has bit 0 set and that is not all ones raises `is_mcast`. It is accepted only if its hash bit is 1. The CRC is reflected, with polynomial 0xEDB88320 and initial value all ones. It takes each byte LSB first and has no final inversion. The hash index is CRC bits 31:26. Index bit 5 picks hash word 0 (selector 2) or word 1 (selector 3), and index bits 4:0 pick the bit inside that word.
- R7: With both hash words all ones, every multicast address is accepted. With both hash words zero, every multicast address is rejected.
- R8: When `promisc` is 1, every address is accepted. This includes a broadcast address while `reject_bcast` is 1, a mismatching unicast address and a multicast address whose hash bit is 0.
- R9: A byte with `byte_sof` high restarts collection, and any partial address is dropped. Bytes after the sixth that arrive without `byte_sof` are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 2 | Word select: 0 station low, 1 station high, 2 hash word 0, 3 hash word 1 |
| cfg_wdata | input | 32 | Configuration write data |
| promisc | input | 1 | Accept every frame |
| reject_bcast | input | 1 | Drop all-ones destination |
| byte_vld | input | 1 | Received byte valid this cycle |
| byte_sof | input | 1 | Qualifies the first destination byte of a frame |
| byte_data | input | 8 | Received byte |
| verdict_vld | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Keep the frame (valid with `verdict_vld`) |
| is_bcast | output | 1 | Destination was all ones |
| is_mcast | output | 1 | Destination was a group address other than broadcast |

## Verification
On every cycle, the embedded assertions check the following. The verdict strobe never lasts two cycles and always follows a received byte. Promiscuous mode always gives accept. A broadcast verdict always follows the `reject_bcast` setting. The broadcast and multicast flags are never raised together. The byte counter never exceeds the address length, and it stays there when extra bytes arrive. Only the directed scenarios can show the remaining behaviour: the exact 48-bit comparison, the byte order of the two station words, the choice of hash word and bit from the CRC, and the effect of idle gaps and of restarting a frame.

// File: rtl/afl_pkg.sv
package afl_pkg;
   localparam int unsigned OCTET_W     = 8;
   localparam int unsigned ADDR_OCTETS = 6;
   localparam int unsigned MAC_W       = OCTET_W * ADDR_OCTETS;
   localparam int unsigned REG_W       = 32;
   localparam int unsigned CRC_W       = 32;
   localparam int unsigned STA_HI_W    = MAC_W - REG_W;
   localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;

   typedef enum logic [1:0] {
      CFG_STA_LO  = 2'd0,
      CFG_STA_HI  = 2'd1,
      CFG_HASH_W0 = 2'd2,
      CFG_HASH_W1 = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/afl_crc_step.sv
module afl_crc_step #(
   parameter int unsigned CRC_W  = 32,
   parameter int unsigned DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);
   logic [DATA_W:0][CRC_W-1:0] stage;

   assign stage[0] = crc_in;

   // one shift-and-reduce stage per data bit, LSB first
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic fb;
      assign fb           = stage[b][0] ^ data_in[b];
      assign stage[b+1]   = (stage[b] >> 1) ^ (fb ? POLY : '0);
   end

   assign crc_out = stage[DATA_W];

   if (DATA_W == 0 || CRC_W < 8) begin : g_bad_cfg
      $error("afl_crc_step: unsupported width combination");
   end
endmodule

// File: rtl/afl_cfg_regs.sv
module afl_cfg_regs
   import afl_pkg::*;
#(
   parameter int unsigned HASH_IDX_W = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [1:0]                   cfg_sel,
   input  logic [REG_W-1:0]             cfg_wdata,
   output logic [MAC_W-1:0]             station,
   output logic [(1<<HASH_IDX_W)-1:0]   hash_tbl
);
   localparam int unsigned HASH_BITS  = 1 << HASH_IDX_W;
   localparam int unsigned HASH_WORDS = HASH_BITS / REG_W;

   if (HASH_IDX_W < 5 || HASH_IDX_W > 6) begin : g_bad_idx
      $error("afl_cfg_regs: hash index width must be 5 or 6");
   end

   logic [REG_W-1:0]    sta_lo_q;
   logic [STA_HI_W-1:0] sta_hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_lo_q <= '0;
         sta_hi_q <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            CFG_STA_LO: sta_lo_q <= cfg_wdata;
            CFG_STA_HI: sta_hi_q <= cfg_wdata[STA_HI_W-1:0];
            default:    ;
         endcase
      end
   end

   // wire byte 0 lands in the top octet of the flat station value
   assign station = {sta_hi_q, sta_lo_q};

   for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hword
      localparam logic [1:0] SEL = 2'(int'(CFG_HASH_W0) + k);
      logic [REG_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        word_q <= '0;
         else if (cfg_we && cfg_sel == SEL) word_q <= cfg_wdata;
      end
      assign hash_tbl[k*REG_W +: REG_W] = word_q;
   end
endmodule

// File: rtl/afl_collect.sv
module afl_collect
   import afl_pkg::*;
#(
   parameter int unsigned HASH_IDX_W = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_vld,
   input  logic                  byte_sof,
   input  logic [OCTET_W-1:0]    byte_data,
   output logic                  addr_done,
   output logic [MAC_W-1:0]      full_addr,
   output logic [HASH_IDX_W-1:0] hash_idx
);
   localparam int unsigned CNT_W = $clog2(ADDR_OCTETS + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_OCTETS);

   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic [CRC_W-1:0] crc_q, crc_base, crc_nx;
   logic [MAC_W-1:0] addr_q;
   logic             take;

   // a start byte always restarts; other bytes count only until full
   assign take     = byte_vld && (byte_sof || cnt_q < CNT_FULL);
   assign crc_base = byte_sof ? '1 : crc_q;
   assign cnt_nx   = byte_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);

   afl_crc_step #(
      .CRC_W  (CRC_W),
      .DATA_W (OCTET_W),
      .POLY   (CRC_POLY_REFL)
   ) u_step (
      .crc_in  (crc_base),
      .data_in (byte_data),
      .crc_out (crc_nx)
   );

   assign full_addr = {addr_q[MAC_W-OCTET_W-1:0], byte_data};
   assign addr_done = take && (cnt_nx == CNT_FULL);
   assign hash_idx  = crc_nx[CRC_W-1 -: HASH_IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_FULL;
         crc_q  <= '1;
         addr_q <= '0;
      end else if (take) begin
         cnt_q  <= cnt_nx;
         crc_q  <= crc_nx;
         addr_q <= full_addr;
      end
   end

   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   a_r9_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_sof && cnt_q == CNT_FULL) |=> (cnt_q == CNT_FULL));
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter
   import afl_pkg::*;
#(
   parameter int unsigned HASH_IDX_W = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        promisc,
   input  logic        reject_bcast,
   input  logic        byte_vld,
   input  logic        byte_sof,
   input  logic [7:0]  byte_data,
   output logic        verdict_vld,
   output logic        accept,
   output logic        is_bcast,
   output logic        is_mcast
);
   localparam int unsigned HASH_BITS = 1 << HASH_IDX_W;

   logic [MAC_W-1:0]      station, full_addr;
   logic [HASH_BITS-1:0]  hash_tbl;
   logic [HASH_IDX_W-1:0] hash_idx;
   logic                  addr_done;
   logic                  bc_c, mc_c, uc_hit, hash_hit, acc_c;

   afl_cfg_regs #(.HASH_IDX_W(HASH_IDX_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .station   (station),
      .hash_tbl  (hash_tbl)
   );

   afl_collect #(.HASH_IDX_W(HASH_IDX_W)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_sof  (byte_sof),
      .byte_data (byte_data),
      .addr_done (addr_done),
      .full_addr (full_addr),
      .hash_idx  (hash_idx)
   );

   // classify: group bit is bit 0 of the first wire byte
   assign bc_c     = &full_addr;
   assign mc_c     = full_addr[MAC_W-OCTET_W] && !bc_c;
   assign uc_hit   = (full_addr == station);
   assign hash_hit = hash_tbl[hash_idx];

   always_comb begin
      if (promisc)    acc_c = 1'b1;
      else if (bc_c)  acc_c = !reject_bcast;
      else if (mc_c)  acc_c = hash_hit;
      else            acc_c = uc_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_vld <= 1'b0;
         accept      <= 1'b0;
         is_bcast    <= 1'b0;
         is_mcast    <= 1'b0;
      end else begin
         verdict_vld <= addr_done;
         if (addr_done) begin
            accept   <= acc_c;
            is_bcast <= bc_c;
            is_mcast <= mc_c;
         end
      end
   end

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |=> !verdict_vld);

   a_r2_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(verdict_vld) |-> $past(byte_vld));

   a_r8_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_vld && $past(promisc)) |-> accept);

   a_r5_bcast_control: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_vld && is_bcast && !$past(promisc)) |-> (accept == !$past(reject_bcast)));

   a_r6_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({is_bcast, is_mcast}));
endmodule

// File: tb/sim_rx_dst_filter.sv
module sim_rx_dst_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        promisc = 1'b0;
   logic        reject_bcast = 1'b0;
   logic        byte_vld = 1'b0;
   logic        byte_sof = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        verdict_vld, accept, is_bcast, is_mcast;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic r_vld, r_acc, r_bc, r_mc, r_early;

   always #2 clk = ~clk;

   rx_dst_filter u0 (
      .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .promisc, .reject_bcast,
      .byte_vld, .byte_sof, .byte_data, .verdict_vld, .accept, .is_bcast, .is_mcast
   );

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [5:0] hidx(input logic [47:0] a);
      logic [31:0] c = '1;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b = a[47-8*i -: 8];
         for (int j = 0; j < 8; j++) begin
            logic fb = c[0] ^ b[j];
            c = (c >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
         end
      end
      return c[31:26];
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_station(input logic [47:0] a);
      wr(2'd0, a[31:0]);
      wr(2'd1, {16'h0, a[47:32]});
   endtask

   task automatic send_addr(input logic [47:0] a, input int gap);
      r_early = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (verdict_vld) r_early = 1'b1;
         byte_vld = 1'b1; byte_sof = (i == 0); byte_data = a[47-8*i -: 8];
         if (i < 5) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               if (verdict_vld) r_early = 1'b1;
               byte_vld = 1'b0; byte_sof = 1'b0;
            end
         end
      end
      @(negedge clk);
      byte_vld = 1'b0; byte_sof = 1'b0;
      r_vld = verdict_vld; r_acc = accept; r_bc = is_bcast; r_mc = is_mcast;
   endtask

   task automatic frame(input string tag, input logic [47:0] a, input int gap,
                        input logic ea, input logic eb, input logic em);
      send_addr(a, gap);
      chk({tag, " early strobe"}, r_early, 1'b0);
      chk({tag, " strobe"}, r_vld, 1'b1);
      chk({tag, " accept"}, r_acc, ea);
      chk({tag, " bcast flag"}, r_bc, eb);
      chk({tag, " mcast flag"}, r_mc, em);
      @(negedge clk);
      chk({tag, " strobe one cycle (R2)"}, verdict_vld, 1'b0);
   endtask

   localparam logic [47:0] STA = 48'h04_06_22_33_44_55;

   task automatic t_reset;
      repeat (2) @(negedge clk);
      chk("R1 vld in reset", verdict_vld, 1'b0);
      chk("R1 accept in reset", accept, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 vld after reset", verdict_vld, 1'b0);
      chk("R1 accept after reset", accept, 1'b0);
   endtask

   task automatic t_unicast;
      set_station(STA);
      frame("R3 exact match", STA, 0, 1'b1, 1'b0, 1'b0);
      frame("R3 last byte differs", STA ^ 48'h1, 0, 1'b0, 1'b0, 1'b0);
      frame("R3 middle byte differs", STA ^ 48'h0000_8000_0000, 0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_byteorder;
      frame("R4 bytes 0/1 swapped", 48'h06_04_22_33_44_55, 0, 1'b0, 1'b0, 1'b0);
      frame("R4 bytes 2..5 reversed", 48'h04_06_55_44_33_22, 0, 1'b0, 1'b0, 1'b0);
      set_station(48'h02_AB_CD_EF_01_23);
      frame("R4 new station", 48'h02_AB_CD_EF_01_23, 0, 1'b1, 1'b0, 1'b0);
      set_station(STA);
   endtask

   task automatic t_bcast;
      reject_bcast = 1'b0;
      frame("R5 bcast allowed", '1, 0, 1'b1, 1'b1, 1'b0);
      reject_bcast = 1'b1;
      frame("R5 bcast rejected", '1, 0, 1'b0, 1'b1, 1'b0);
      reject_bcast = 1'b0;
   endtask

   task automatic t_mcast_hash;
      logic [47:0] m = 48'h01_00_5E_00_00_FB;
      logic [5:0]  ix = hidx(m);
      logic [31:0] one = 32'h1 << ix[4:0];
      logic [31:0] other = 32'h1 << 5'(ix[4:0] + 5'd1);
      wr(ix[5] ? 2'd3 : 2'd2, one);
      wr(ix[5] ? 2'd2 : 2'd3, 32'h0);
      frame("R6 hash bit set", m, 0, 1'b1, 1'b0, 1'b1);
      wr(ix[5] ? 2'd3 : 2'd2, other);
      wr(ix[5] ? 2'd2 : 2'd3, 32'hFFFF_FFFF);
      frame("R6 wrong bit and word", m, 0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_mcast_all;
      wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
      frame("R7 all ones A", 48'h33_33_00_00_00_01, 0, 1'b1, 1'b0, 1'b1);
      frame("R7 all ones B", 48'hFF_FF_FF_FF_FF_FE, 0, 1'b1, 1'b0, 1'b1);
      wr(2'd2, 32'h0); wr(2'd3, 32'h0);
      frame("R7 all zero", 48'h33_33_00_00_00_01, 0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_promisc;
      promisc = 1'b1; reject_bcast = 1'b1;
      frame("R8 bcast", '1, 0, 1'b1, 1'b1, 1'b0);
      frame("R8 foreign unicast", 48'h00_11_22_33_44_66, 0, 1'b1, 1'b0, 1'b0);
      frame("R8 unhashed mcast", 48'h01_00_5E_7F_00_01, 0, 1'b1, 1'b0, 1'b1);
      promisc = 1'b0; reject_bcast = 1'b0;
   endtask

   task automatic t_gaps;
      frame("R2 idle gaps", STA, 3, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_restart;
      logic seen = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         byte_vld = 1'b1; byte_sof = (i == 0); byte_data = 8'hA0 + 8'(i);
      end
      frame("R9 restart after partial", STA, 0, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (verdict_vld) seen = 1'b1;
         byte_vld = 1'b1; byte_sof = 1'b0; byte_data = 8'h55;
      end
      @(negedge clk);
      if (verdict_vld) seen = 1'b1;
      byte_vld = 1'b0;
      @(negedge clk);
      if (verdict_vld) seen = 1'b1;
      chk("R9 extra bytes give no verdict", seen, 1'b0);
      frame("R9 next frame after extras", STA ^ 48'h100, 0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_unicast();
      t_byteorder();
      t_bcast();
      t_mcast_hash();
      t_mcast_all();
      t_promisc();
      t_gaps();
      t_restart();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule